// File: doc/BRIEF.md
# Dual Auxiliary Clock Output Divider

This block derives two auxiliary clock pins from the main oscillator. The first pin is either a buffered copy of the oscillator or the oscillator halved. The second pin divides the oscillator by 7.5, 6, 12 or 10. With this set of ratios, one standard baud-rate clock of 1.8432 MHz can be made from crystals of 13.824, 11.0592, 22.1184 or 18.432 MHz. Each pin has its own enable bit, and a disabled pin sits at logic zero.

The control bits come in as plain parallel inputs that are sampled on the rising oscillator edge. Each output is built from one flop on the rising edge and one flop on the falling edge. This lets the fractional ratio place its edges on half-cycle boundaries. A new setting is held back until the running waveform reaches the end of its low phase. The pins therefore never emit a shortened pulse.

Top module: `clkout_gen`

## Requirements
- R1: Reset is synchronous and active high. While it is held, and until an enable is sampled high afterwards, both outputs are 0 and both channels are disabled.
- R2: With the first channel enabled and `ck1_div2`=0, `ck1_out` is 1 during the high half of each oscillator cycle and 0 during the low half.
- R3: With the first channel enabled and `ck1_div2`=1, `ck1_out` is high for one full oscillator cycle and then low for one full cycle.
- R4: With `ck2_sel`=2'b00, `ck2_out` has a period of exactly 15 oscillator half-cycles: 7 half-cycles high, then 8 low. Successive rising edges therefore fall alternately on rising and falling oscillator edges.
- R5: `ck2_sel`=2'b01, 2'b10 and 2'b11 divide by 6, 12 and 10 with a 50% duty cycle. Each period starts with its high phase and is aligned to a rising oscillator edge.
- R6: While a channel's enable is low and its last pattern has finished, its output is held at 0.
- R7: A change of enable or select is only taken up at the end of the current pattern, and a pattern always ends in a low phase. A pattern is one output period, or two periods for the 7.5 ratio. Every high pulse has its full length for the mode that produced it.
- R8: When a channel is idle and its enable is sampled high on rising edge k, its output first rises at rising edge k+1, at the start of a new pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main oscillator; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| ck1_en | input | 1 | First channel enable |
| ck1_div2 | input | 1 | First channel ratio: 0 buffered, 1 divide by two |
| ck2_en | input | 1 | Second channel enable |
| ck2_sel | input | 2 | Second channel ratio: 00 /7.5, 01 /6, 10 /12, 11 /10 |
| ck1_out | output | 1 | First auxiliary clock pin |
| ck2_out | output | 1 | Second auxiliary clock pin |

## Verification
The bound assertions run on every cycle. They check that both pins are low throughout reset and stay low once a channel has been disabled for long enough. They also check that a settled mode repeats with its own period at both oscillator edges: the buffered and halved first channel, the 15-cycle repeat of the fractional ratio, and the half-period inversion of the integer ratios. Only the bench's scenarios can show where a new setting takes effect relative to the running pattern, the one-cycle start-up latency from idle, and the absence of a shortened pulse when the mode or enable changes mid-pattern. The bench covers these with a half-cycle reference model and a record of every high pulse width.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  // Ratios of the second channel, in oscillator cycles (integer) or half-cycles (fractional)
  parameter int unsigned DIV_A       = 6;
  parameter int unsigned DIV_B       = 12;
  parameter int unsigned DIV_C       = 10;
  parameter int unsigned FRAC_HALVES = 15;

  localparam int unsigned MAX_LAST = FRAC_HALVES - 1;
  localparam int unsigned CNT_W    = $clog2(MAX_LAST + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  // Waveform value for the two halves of one oscillator cycle
  typedef struct packed {
    logic even;  // half after the rising edge
    logic odd;   // half after the falling edge
  } slot_t;

  typedef enum logic [1:0] {
    SEL_FRAC = 2'b00,
    SEL_A    = 2'b01,
    SEL_B    = 2'b10,
    SEL_C    = 2'b11
  } ck2_sel_e;

  // Last counter value of a pattern; a fractional pattern spans two periods
  function automatic cnt_t pattern_last(input bit fast, input logic [1:0] sel);
    if (fast) begin
      return sel[0] ? cnt_t'(1) : cnt_t'(0);
    end
    case (ck2_sel_e'(sel))
      SEL_FRAC: return cnt_t'(FRAC_HALVES - 1);
      SEL_A:    return cnt_t'(DIV_A - 1);
      SEL_B:    return cnt_t'(DIV_B - 1);
      default:  return cnt_t'(DIV_C - 1);
    endcase
  endfunction

  function automatic slot_t slot_bits(input bit fast, input logic [1:0] sel, input cnt_t cnt);
    slot_t       s;
    int unsigned cv;
    int unsigned h;
    int unsigned n;
    cv = 32'(cnt);
    if (fast) begin
      if (!sel[0]) s = '{even: 1'b1, odd: 1'b0};
      else         s = (cv == 0) ? '{even: 1'b1, odd: 1'b1} : '{even: 1'b0, odd: 1'b0};
    end else if (ck2_sel_e'(sel) == SEL_FRAC) begin
      h = 2 * cv;
      s.even = ((h % FRAC_HALVES) < (FRAC_HALVES / 2));
      s.odd  = (((h + 1) % FRAC_HALVES) < (FRAC_HALVES / 2));
    end else begin
      n = 32'(pattern_last(fast, sel)) + 1;
      s.even = (cv < n / 2);
      s.odd  = (cv < n / 2);
    end
    return s;
  endfunction

endpackage

// File: rtl/clkout_seq.sv
module clkout_seq
  import clkout_pkg::*;
#(
  parameter bit FAST = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] sel,
  output slot_t      slot
);

  logic       act_en;
  logic [1:0] act_sel;
  cnt_t       cnt;
  logic       at_end;

  // New settings are taken only when idle or on the final (low) cycle of a pattern
  assign at_end = !act_en || (cnt == pattern_last(FAST, act_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_en  <= 1'b0;
      act_sel <= 2'b00;
      cnt     <= '0;
    end else if (at_end) begin
      act_en  <= en;
      act_sel <= sel;
      cnt     <= '0;
    end else begin
      cnt <= cnt + cnt_t'(1);
    end
  end

  always_comb begin
    slot = act_en ? slot_bits(FAST, act_sel, cnt) : '0;
  end

endmodule

// File: rtl/clkout_dualedge.sv
module clkout_dualedge
  import clkout_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  slot_t slot,
  output logic  pin
);

  logic pos_q;
  logic neg_q;
  logic odd_q;

  // Each flop flips only on its own edge, so the XOR never sees two inputs move at once
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= 1'b0;
      odd_q <= 1'b0;
    end else begin
      pos_q <= slot.even ^ neg_q;
      odd_q <= slot.odd;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= odd_q ^ pos_q;
  end

  assign pin = pos_q ^ neg_q;

endmodule

// File: rtl/clkout_chan.sv
module clkout_chan
  import clkout_pkg::*;
#(
  parameter bit FAST = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       pin
);

  slot_t slot;

  clkout_seq #(.FAST(FAST)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .sel  (sel),
    .slot (slot)
  );

  clkout_dualedge u_out (
    .clk  (clk),
    .rst  (rst),
    .slot (slot),
    .pin  (pin)
  );

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       ck1_en,
  input  logic       ck1_div2,
  input  logic       ck2_en,
  input  logic [1:0] ck2_sel,
  output logic       ck1_out,
  output logic       ck2_out
);

  localparam int unsigned NUM_CH = 2;

  logic [NUM_CH-1:0]      en_v;
  logic [NUM_CH-1:0][1:0] sel_v;
  logic [NUM_CH-1:0]      pin_v;

  assign en_v  = {ck2_en, ck1_en};
  assign sel_v = {ck2_sel, {1'b0, ck1_div2}};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    clkout_chan #(.FAST(g == 0)) u_ch (
      .clk (clk),
      .rst (rst),
      .en  (en_v[g]),
      .sel (sel_v[g]),
      .pin (pin_v[g])
    );
  end

  assign ck1_out = pin_v[0];
  assign ck2_out = pin_v[1];

endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       ck1_en,
  input logic       ck1_div2,
  input logic       ck2_en,
  input logic [1:0] ck2_sel,
  input logic       ck1_out,
  input logic       ck2_out
);

  localparam int unsigned SETTLE = 40;

  logic [1:0] cfg1_q;
  logic [2:0] cfg2_q;
  logic [5:0] st1;
  logic [5:0] st2;
  logic       same1;
  logic       same2;
  logic       ok1;
  logic       ok2;

  assign same1 = ({ck1_en, ck1_div2} == cfg1_q);
  assign same2 = ({ck2_en, ck2_sel} == cfg2_q);
  assign ok1   = same1 && (st1 >= 6'(SETTLE));
  assign ok2   = same2 && (st2 >= 6'(SETTLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg1_q <= '0;
      cfg2_q <= '0;
      st1    <= '0;
      st2    <= '0;
    end else begin
      cfg1_q <= {ck1_en, ck1_div2};
      cfg2_q <= {ck2_en, ck2_sel};
      st1    <= same1 ? ((st1 == 6'd63) ? st1 : st1 + 6'd1) : 6'd0;
      st2    <= same2 ? ((st2 == 6'd63) ? st2 : st2 + 6'd1) : 6'd0;
    end
  end

  a_r1_reset_low: assert property (@(posedge clk) (rst && $past(rst)) |-> (!ck1_out && !ck2_out));

  a_r2_buf_low:  assert property (@(posedge clk) disable iff (rst) (ok1 && ck1_en && !ck1_div2) |-> !ck1_out);
  a_r2_buf_high: assert property (@(negedge clk) disable iff (rst) (ok1 && ck1_en && !ck1_div2) |-> ck1_out);

  a_r3_half_rate: assert property (@(posedge clk) disable iff (rst)
    (ok1 && ck1_en && ck1_div2) |-> (ck1_out != $past(ck1_out)));

  a_r4_frac_repeat_p: assert property (@(posedge clk) disable iff (rst)
    (ok2 && ck2_en && ck2_sel == 2'b00) |-> (ck2_out == $past(ck2_out, 15)));
  a_r4_frac_repeat_n: assert property (@(negedge clk) disable iff (rst)
    (ok2 && ck2_en && ck2_sel == 2'b00) |-> (ck2_out == $past(ck2_out, 15)));

  a_r5_div6:  assert property (@(posedge clk) disable iff (rst)
    (ok2 && ck2_en && ck2_sel == 2'b01) |-> (ck2_out != $past(ck2_out, 3)));
  a_r5_div12: assert property (@(posedge clk) disable iff (rst)
    (ok2 && ck2_en && ck2_sel == 2'b10) |-> (ck2_out != $past(ck2_out, 6)));
  a_r5_div10: assert property (@(posedge clk) disable iff (rst)
    (ok2 && ck2_en && ck2_sel == 2'b11) |-> (ck2_out != $past(ck2_out, 5)));

  a_r6_ck1_off:   assert property (@(posedge clk) disable iff (rst) (ok1 && !ck1_en) |-> !ck1_out);
  a_r6_ck2_off:   assert property (@(posedge clk) disable iff (rst) (ok2 && !ck2_en) |-> !ck2_out);
  a_r6_ck2_off_n: assert property (@(negedge clk) disable iff (rst) (ok2 && !ck2_en) |-> !ck2_out);

endmodule

bind clkout_gen clkout_gen_chk u_chk (.*);

// File: tb/sim_clkout_gen.sv
`timescale 1ns/100ps
module sim_clkout_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ck1_en = 1'b0;
  logic       ck1_div2 = 1'b0;
  logic       ck2_en = 1'b0;
  logic [1:0] ck2_sel = 2'b00;
  logic       ck1_out;
  logic       ck2_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkout_gen u0 (
    .clk(clk), .rst(rst), .ck1_en(ck1_en), .ck1_div2(ck1_div2),
    .ck2_en(ck2_en), .ck2_sel(ck2_sel), .ck1_out(ck1_out), .ck2_out(ck2_out)
  );

  task automatic chk(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, got, exp);
    end
  endtask

  // Reference: waveform in half-cycles, period ph, high for the first ph/2 halves
  function automatic int period_halves(input int ch, input int sel);
    if (ch == 0) return (sel[0]) ? 4 : 2;
    case (sel)
      0: return 15;
      1: return 12;
      2: return 24;
      default: return 20;
    endcase
  endfunction

  function automatic int pattern_halves(input int ch, input int sel);
    if (ch == 1 && sel == 0) return 30;
    return period_halves(ch, sel);
  endfunction

  function automatic string mode_tag(input int ch, input bit en, input int sel);
    if (!en) return "R6";
    if (ch == 0) return sel[0] ? "R3" : "R2";
    return (sel == 0) ? "R4" : "R5";
  endfunction

  bit    m_en [2];
  int    m_sel[2];
  int    m_pos[2];
  int    run  [2];
  int    bad_runs = 0;

  function automatic bit run_ok(input int ch, input int len);
    if (ch == 0) return (len == 1) || (len == 2);
    return (len == 7) || (len == 6) || (len == 12) || (len == 10);
  endfunction

  task automatic track(input int ch, input bit v);
    if (v) run[ch]++;
    else if (run[ch] > 0) begin
      if (!run_ok(ch, run[ch])) begin
        bad_runs++;
        $display("note: channel %0d high pulse of %0d halves at %0t", ch, run[ch], $time);
      end
      run[ch] = 0;
    end
  endtask

  always @(posedge clk) begin
    bit    e[2];
    bit    o[2];
    string tg[2];
    bit    in_en[2];
    int    in_sel[2];
    in_en[0] = ck1_en;  in_sel[0] = int'(ck1_div2);
    in_en[1] = ck2_en;  in_sel[1] = int'(ck2_sel);
    for (int ch = 0; ch < 2; ch++) begin
      if (rst) begin
        e[ch] = 0; o[ch] = 0; tg[ch] = "R1";
        m_en[ch] = 0; m_sel[ch] = 0; m_pos[ch] = 0;
      end else begin
        tg[ch] = mode_tag(ch, m_en[ch], m_sel[ch]);
        if (m_en[ch]) begin
          e[ch] = (m_pos[ch] % period_halves(ch, m_sel[ch])) < period_halves(ch, m_sel[ch]) / 2;
          o[ch] = ((m_pos[ch] + 1) % period_halves(ch, m_sel[ch])) < period_halves(ch, m_sel[ch]) / 2;
        end else begin
          e[ch] = 0; o[ch] = 0;
        end
        // R7/R8: settings are taken only when idle or at the end of the pattern
        if (!m_en[ch] || (m_pos[ch] + 2 >= pattern_halves(ch, m_sel[ch]))) begin
          m_en[ch] = in_en[ch]; m_sel[ch] = in_sel[ch]; m_pos[ch] = 0;
        end else begin
          m_pos[ch] += 2;
        end
      end
    end
    #2;
    chk(ck1_out, e[0], {tg[0], " ck1 high half"});
    chk(ck2_out, e[1], {tg[1], " ck2 high half"});
    track(0, ck1_out); track(1, ck2_out);
    #2;
    chk(ck1_out, o[0], {tg[0], " ck1 low half"});
    chk(ck2_out, o[1], {tg[1], " ck2 low half"});
    track(0, ck1_out); track(1, ck2_out);
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    cycles(6);
    rst = 1'b0;
    cycles(20);                              // R6: both idle after reset
    ck1_en = 1'b1;                           // R2 buffered
    cycles(30);
    ck1_div2 = 1'b1;                         // R3 and R7 switch
    cycles(30);
    ck2_en = 1'b1; ck2_sel = 2'b00;          // R4
    cycles(70);
    ck2_sel = 2'b01;                         // R7 mid-pattern change
    cycles(40);
    ck2_sel = 2'b10;
    cycles(53);
    ck2_sel = 2'b11;
    cycles(47);
    ck2_en = 1'b0;                           // R6/R7 disable mid-pattern
    ck1_en = 1'b0;
    cycles(40);
    // R8: enable from idle, first rise one edge after sampling
    ck2_sel = 2'b01; ck2_en = 1'b1;
    @(posedge clk); #2;
    chk(ck2_out, 1'b0, "R8 still low on sampling edge");
    @(posedge clk); #2;
    chk(ck2_out, 1'b1, "R8 rises on following edge");
    #2;
    cycles(30);
    ck2_sel = 2'b00;
    cycles(13);
    ck2_en = 1'b0;
    cycles(40);
    rst = 1'b1;                              // R1 reset while running
    ck1_en = 1'b1;
    cycles(5);
    rst = 1'b0; ck1_en = 1'b0;
    cycles(10);
    chk(bad_runs == 0, 1'b1, "R7 every high pulse full length");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule